// File: doc/BRIEF.md
# Preset-Reload Divide-by-Five Counter

This block divides its clock by five with a synchronous binary up-counter that never counts from zero. When the counter reaches its all-ones terminal value, a reload is issued and the counter jumps back to a preset value. It therefore cycles through exactly five states. The divided output is the terminal-count decode: it is high for one input cycle in every five.

A parameter picks one of two reload paths. In the direct path the terminal-count decode drives the reload at once, so the counter reloads on the edge right after it reaches all ones. In the registered path the decode passes through one flip-flop before it reaches the reload control. The reload then arrives one cycle later, and the preset is raised by one so that the ratio stays at five. This takes the decode-to-load path off the critical timing arc. A synchronous seed input can place the counter in any state, including the ones outside the loop. This is used to show that every state rejoins the five-state loop.

Top module: `divfive_preset_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter takes the preset value on that edge and any pending registered reload is cleared. Reset takes priority over seeding. The preset is 11 in the direct variant and 12 in the registered variant.
- R2: In the direct variant (`PIPELINED = 0`) the count runs 11, 12, 13, 14, 15, 11, ... repeatedly.
- R3: In the registered variant (`PIPELINED = 1`) the count runs 12, 13, 14, 15, 0, 12, ... repeatedly.
- R4: `div_o` is high exactly when `count_o` equals 15 (all ones). Once in the loop, consecutive rising edges of `div_o` are exactly five clock cycles apart.
- R5: When no reload, seed or reset applies, each clock edge adds one to the count, modulo 16.
- R6: A clock edge with `seed_en` high and `rst_n` high loads `seed_val` into the counter and clears any pending registered reload.
- R7: From any seeded value 0 to 15, the counter reaches its preset within 18 clock edges after the seed, and from then on it stays inside its five-state loop.
- R8: In the registered variant, the reload happens on the second edge after the count reaches 15, that is, while the count shows 0. Two reloads are never issued on consecutive edges.
- R9: In the direct variant, the reload happens on the first edge after the count reaches 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_en | input | 1 | Synchronous load of `seed_val` into the counter |
| seed_val | input | WIDTH | Value loaded when `seed_en` is high |
| count_o | output | WIDTH | Present counter state |
| div_o | output | 1 | Divided clock, high for one cycle in five |

## Verification
The assertions assume that `rst_n` is low from time zero through at least one rising edge, and that every input changes only away from the rising clock edge. They allow `seed_en` to arrive at any cycle, including while a registered reload is pending. For that reason each step and loop property excludes the cycle after a seed. The stimulus holds reset from the start, drives every input on the falling edge, and seeds all sixteen states, the unused ones included. It also applies reset and seed together to exercise their priority.

// File: rtl/divfive_pkg.sv
// Package: shared helpers for the preset-reload divider.
// Assumes ratio < 2**width, so that the preset fits in the counter.
package divfive_pkg;

    // Preset value that gives 'ratio' states ending at all ones. The registered
    // reload path needs one more, because its extra state is the wrap to zero.
    function automatic int unsigned reload_value(int unsigned width,
                                                 int unsigned ratio,
                                                 bit          pipelined);
        return (32'd1 << width) - ratio + (pipelined ? 32'd1 : 32'd0);
    endfunction

endpackage

// File: rtl/divfive_count_core.sv
// Module: loadable binary up-counter with terminal-count decode.
// Priority on each edge: reset, then seed, then reload, then increment.
// Assumes reset is held low for at least one edge at start-up.
module divfive_count_core #(
    parameter int unsigned          WIDTH  = 4,
    parameter logic [WIDTH-1:0]     PRESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_en_i,
    input  logic [WIDTH-1:0] seed_val_i,
    input  logic             load_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_o
);

    logic [WIDTH-1:0] count_q;
    logic             past_ok;

    // Counter state: reset, seed, reload or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= PRESET;
        end else if (seed_en_i) begin
            count_q <= seed_val_i;
        end else if (load_i) begin
            count_q <= PRESET;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // Terminal-count decode.
    assign carry_o = &count_q;
    assign count_o = count_q;

    // R5: a plain cycle adds exactly one.
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!seed_en_i && !load_i)) |-> count_q == WIDTH'($past(count_q) + 1'b1));

    // R6: a seed lands on the next edge.
    a_r6_seed_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(seed_en_i)) |-> count_q == $past(seed_val_i));

    // R9: a reload request lands the preset.
    a_r9_reload_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load_i && !seed_en_i)) |-> count_q == PRESET);

endmodule

// File: rtl/divfive_reload_path.sv
// Module: path from terminal-count decode to counter reload.
// PIPELINED = 0 passes the decode straight through. PIPELINED = 1 registers it,
// with the register cleared by reset or a seed. Assumes carry_i comes from a register.
module divfive_reload_path #(
    parameter bit PIPELINED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic carry_i,
    output logic load_o
);

    logic past_ok;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    generate
        if (PIPELINED) begin : g_registered
            logic pend_q;

            // One-stage delay of the terminal-count decode.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= carry_i;
                end
            end

            assign load_o = pend_q;

            // R8: a terminal count reloads one cycle later.
            a_r8_load_follows_carry: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(carry_i && !clr_i)) |-> load_o);
        end else begin : g_direct
            // Direct reload from the decode.
            assign load_o = carry_i;
        end
    endgenerate

    // R8: never two reloads back to back unless a seed intervenes.
    a_r8_load_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load_o && !clr_i)) |-> !load_o);

endmodule

// File: rtl/divfive_preset_counter.sv
// Module: divide-by-RATIO clock divider built from a preset-reload up-counter.
// div_o is the terminal-count decode, high one cycle in RATIO.
// Assumes synchronous inputs and reset held low at start-up.
module divfive_preset_counter #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned RATIO     = 5,
    parameter bit          PIPELINED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_en,
    input  logic [WIDTH-1:0] seed_val,
    output logic [WIDTH-1:0] count_o,
    output logic             div_o
);

    import divfive_pkg::*;

    localparam logic [WIDTH-1:0] PRESET = WIDTH'(reload_value(WIDTH, RATIO, PIPELINED));

    logic carry;
    logic load;
    logic in_loop;
    logic past_ok;

    divfive_count_core #(
        .WIDTH  (WIDTH),
        .PRESET (PRESET)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_en_i  (seed_en),
        .seed_val_i (seed_val),
        .load_i     (load),
        .count_o    (count_o),
        .carry_o    (carry)
    );

    divfive_reload_path #(
        .PIPELINED (PIPELINED)
    ) u_reload (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (seed_en),
        .carry_i (carry),
        .load_o  (load)
    );

    assign div_o = carry;

    // Loop membership: preset and above, plus zero while a reload is pending.
    always_comb begin
        in_loop = (count_o >= PRESET) || (PIPELINED && (count_o == '0) && load);
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // R7: once inside the loop, it never leaves without a seed.
    a_r7_stay_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_loop && !seed_en)) |-> in_loop);

    // R4: the state after a divided pulse is the reload target (or zero when registered).
    a_r4_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(div_o && !seed_en)) |-> count_o == (PIPELINED ? '0 : PRESET));

endmodule

// File: tb/divfive_preset_counter_bench.sv
`timescale 1ns/1ps
// Bench: runs both reload variants side by side against behavioural models.
module divfive_preset_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seed_en = 1'b0;
    logic [3:0] seed_val = 4'd0;
    logic [3:0] cnt_d, cnt_p;
    logic       div_d, div_p;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // Behavioural models: integers only.
    int m_d, m_p;
    bit m_pend;

    // Period trackers.
    int cyc = 0;
    int last_d = -1, last_p = -1;
    bit prev_d = 1'b0, prev_p = 1'b0;

    always #2.5 clk = ~clk;

    divfive_preset_counter #(.WIDTH(4), .RATIO(5), .PIPELINED(1'b0)) u_divfive_preset_counter (
        .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .seed_val(seed_val),
        .count_o(cnt_d), .div_o(div_d));

    divfive_preset_counter #(.WIDTH(4), .RATIO(5), .PIPELINED(1'b1)) u_divfive_preset_counter_pipe (
        .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .seed_val(seed_val),
        .count_o(cnt_p), .div_o(div_p));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model update per requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_d <= 11; m_p <= 12; m_pend <= 1'b0;
        end else if (seed_en) begin
            m_d <= seed_val; m_p <= seed_val; m_pend <= 1'b0;
        end else begin
            m_d    <= (m_d == 15) ? 11 : m_d + 1;
            m_pend <= (m_p == 15);
            m_p    <= m_pend ? 12 : (m_p + 1) % 16;
        end
    end

    // Lockstep compare and period tracking, away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cmp_on) begin
            check("R2 R5 R9 direct count", 8'(cnt_d), 8'(m_d));
            check("R3 R5 R8 registered count", 8'(cnt_p), 8'(m_p));
            check("R4 direct div", 8'(div_d), 8'(m_d == 15));
            check("R4 registered div", 8'(div_p), 8'(m_p == 15));
            if (div_d && !prev_d) begin
                if (last_d >= 0) check("R4 direct period", 8'(cyc - last_d), 8'd5);
                last_d <= cyc;
            end
            if (div_p && !prev_p) begin
                if (last_p >= 0) check("R4 registered period", 8'(cyc - last_p), 8'd5);
                last_p <= cyc;
            end
        end
        prev_d <= div_d;
        prev_p <= div_p;
        if (seed_en || !rst_n) begin
            last_d <= -1;
            last_p <= -1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n_d, n_p;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 direct preset", 8'(cnt_d), 8'd11);
        check("R1 registered preset", 8'(cnt_p), 8'd12);
        check("R1 direct div low", 8'(div_d), 8'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (40) @(negedge clk);

        // R6 R7: seed every state and watch recovery.
        for (int v = 0; v < 16; v++) begin
            seed_en = 1'b1;
            seed_val = 4'(v);
            @(negedge clk);
            seed_en = 1'b0;
            check("R6 direct seed", 8'(cnt_d), 8'(v));
            check("R6 registered seed", 8'(cnt_p), 8'(v));
            n_d = -1;
            n_p = -1;
            for (int i = 1; i <= 20; i++) begin
                @(negedge clk);
                if (n_d < 0 && cnt_d == 4'd11) n_d = i;
                if (n_p < 0 && cnt_p == 4'd12) n_p = i;
            end
            check("R7 direct recovery", 8'(n_d > 0 && n_d <= 18), 8'd1);
            check("R7 registered recovery", 8'(n_p > 0 && n_p <= 18), 8'd1);
            repeat (6) @(negedge clk);
        end

        // R8: seed 15 into the registered variant, reload two edges later.
        seed_en = 1'b1;
        seed_val = 4'd15;
        @(negedge clk);
        seed_en = 1'b0;
        @(negedge clk);
        check("R8 registered wraps to zero", 8'(cnt_p), 8'd0);
        check("R9 direct reloads at once", 8'(cnt_d), 8'd11);
        @(negedge clk);
        check("R8 registered reload", 8'(cnt_p), 8'd12);

        // R1: reset beats seed.
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        seed_en = 1'b1;
        seed_val = 4'd3;
        @(negedge clk);
        rst_n = 1'b1;
        seed_en = 1'b0;
        check("R1 reset over seed direct", 8'(cnt_d), 8'd11);
        check("R1 reset over seed registered", 8'(cnt_p), 8'd12);
        repeat (20) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule